// File: doc/BRIEF.md
# Prefixed Opcode Fetch Decoder

This block walks an instruction stream one byte per clock through a byte-wide read port and works out which opcode sits at the program counter. An opcode can be a single byte, a byte behind the 0x0F escape, or a byte behind 0xF2 or 0xF3. After 0xF2 or 0xF3 a further 0x0F can follow, and then a third byte. Each accepted opcode comes out as a one-cycle strobe. The strobe carries the collected bytes, the opcode length, a tag for the path the decode took, and the address of the opcode's first byte.

The halt byte 0xF4 is accepted like any other single-byte opcode. It also sends the program counter to an end-of-program address that arrives on an input. If a byte is not in the table for its level, the block raises an error that reports the level and the path. A fault signalled by memory during a fetch also raises the error. After any error the block stops fetching and waits for reset. Decoding of operands and execution are handled by other blocks. A controller requests each decode with a one-cycle step pulse while the block is idle.

Top module: `opc_fetch_decoder`

## Requirements
- R1: Every fetch cycle asserts `mem_rd` with `mem_addr` equal to `pc`. After a fetch that does not fault and is not the halt byte, `pc` is one higher.
- R2: A first byte of 0xF4 produces `op_valid` with `op_halt`=1, class 0 and length 1. On the same cycle `pc` equals `end_addr`.
- R3: First bytes 0x90, 0xC3 and 0x50 to 0x5F are accepted as class 0 (single) with length 1.
- R4: A first byte of 0x0F fetches a second byte. Second bytes 0x80 to 0x8F and 0xAF are accepted as class 1 with length 2.
- R5: A first byte of 0xF2 or 0xF3 fetches a second byte. After 0xF3 a second byte of 0x90 is accepted as class 4 with length 2. After either prefix a second byte of 0x0F fetches a third byte. After 0xF2 any other second byte is an error.
- R6: Third bytes 0x10, 0x11, 0x58 and 0x59 after 0xF2 0x0F are accepted as class 3. Third bytes 0x10, 0x11, 0x2A and 0x2C after 0xF3 0x0F are accepted as class 5. Both have length 3.
- R7: A byte that is not in the table of its level sets `err` with `err_fault`=0. `err_level` gives the level (1, 2 or 3) and `err_path` gives the path class reached so far. Class codes: 0 single, 1 0x0F, 2 0xF2, 3 0xF2 0x0F, 4 0xF3, 5 0xF3 0x0F.
- R8: `op_start` equals the value `pc` held when the step was taken, that is, the address of the first opcode byte.
- R9: Once `err` is set it stays set until reset. While it is set, `mem_rd` and `op_valid` stay low, `pc` holds, and `step` has no effect.
- R10: When `mem_fault` is high during a fetch, decoding stops. `err` and `err_fault` are set, `err_level` and `err_path` report where the fault hit, and `pc` does not advance.
- R11: After reset `pc` equals RESET_PC (1), and `op_valid`, `err` and `mem_rd` are low.
- R12: `op_bytes` holds the first byte in bits 7:0, the second in 15:8 and the third in 23:16. Lanes past the opcode length read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step | input | 1 | Request to decode the opcode at `pc` (taken while idle) |
| end_addr | input | AW | Address loaded into `pc` by the halt byte |
| mem_rd | output | 1 | Fetch strobe |
| mem_addr | output | AW | Fetch address |
| mem_rdata | input | 8 | Byte read, valid in the same cycle as the address |
| mem_fault | input | 1 | Access fault for the current fetch |
| pc | output | AW | Program counter |
| op_valid | output | 1 | One-cycle strobe for an accepted opcode |
| op_bytes | output | 24 | Collected opcode bytes |
| op_len | output | 2 | Opcode length in bytes |
| op_class | output | 3 | Path class of the accepted opcode |
| op_halt | output | 1 | Accepted opcode was the halt byte |
| op_start | output | AW | Address of the opcode's first byte |
| err | output | 1 | Sticky error |
| err_fault | output | 1 | Error came from a memory fault |
| err_level | output | 2 | Fetch level at which the error arose |
| err_path | output | 3 | Path class at the time of the error |

## Verification
The hardest situations to reach are a fault or a rejected byte deep in a chain. An example is a third byte after 0xF3 0x0F that is legal only on the 0xF2 path, where the block must report level 3 together with the right path. The bench reaches these by placing whole prefix chains in its byte memory. It then arms the fault on the address of one chosen byte in the chain, resetting between runs because errors are sticky. A second hard case is the halt jump followed by a new decode at the end address. The bench steps a 0xF4 and then steps again at the address it expects the jump to land on.

// File: rtl/opc_pkg.sv
package opc_pkg;

    localparam int BYTE_W    = 8;
    localparam int MAX_BYTES = 3;
    localparam int LVL_W     = 2;

    localparam logic [BYTE_W-1:0] OPC_ESC   = 8'h0F;
    localparam logic [BYTE_W-1:0] OPC_HALT  = 8'hF4;
    localparam logic [BYTE_W-1:0] PFX_LO    = 8'hF2;
    localparam logic [BYTE_W-1:0] PFX_HI    = 8'hF3;
    localparam logic [BYTE_W-1:0] OPC_SPIN  = 8'h90;

    typedef enum logic [2:0] {
        P_ONE   = 3'd0,
        P_ESC   = 3'd1,
        P_LO    = 3'd2,
        P_LO_E  = 3'd3,
        P_HI    = 3'd4,
        P_HI_E  = 3'd5
    } path_e;

    typedef enum logic [1:0] {
        A_BAD  = 2'd0,
        A_DONE = 2'd1,
        A_ESC  = 2'd2,
        A_HALT = 2'd3
    } act_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_FETCH = 2'd1,
        S_STOP  = 2'd2
    } st_e;

    // level-1 accept set: nop, return, register push/pop block
    function automatic logic tbl_one(input logic [BYTE_W-1:0] b);
        return (b == OPC_SPIN) || (b == 8'hC3) || (b[7:4] == 4'h5);
    endfunction

    // second byte behind the escape: conditional branch block and multiply
    function automatic logic tbl_esc(input logic [BYTE_W-1:0] b);
        return (b[7:4] == 4'h8) || (b == 8'hAF);
    endfunction

    function automatic logic tbl_lo_esc(input logic [BYTE_W-1:0] b);
        return (b == 8'h10) || (b == 8'h11) || (b == 8'h58) || (b == 8'h59);
    endfunction

    function automatic logic tbl_hi_esc(input logic [BYTE_W-1:0] b);
        return (b == 8'h10) || (b == 8'h11) || (b == 8'h2A) || (b == 8'h2C);
    endfunction

endpackage

// File: rtl/opc_classify.sv
module opc_classify
    import opc_pkg::*;
(
    input  path_e              path,
    input  logic [BYTE_W-1:0]  byte_in,
    output act_e               act,
    output path_e              nxt_path
);

    always_comb begin
        act      = A_BAD;
        nxt_path = path;
        unique case (path)
            P_ONE: begin
                if (byte_in == OPC_HALT) begin
                    act = A_HALT;
                end else if (byte_in == OPC_ESC) begin
                    act      = A_ESC;
                    nxt_path = P_ESC;
                end else if (byte_in == PFX_LO) begin
                    act      = A_ESC;
                    nxt_path = P_LO;
                end else if (byte_in == PFX_HI) begin
                    act      = A_ESC;
                    nxt_path = P_HI;
                end else if (tbl_one(byte_in)) begin
                    act = A_DONE;
                end
            end
            P_ESC: begin
                if (tbl_esc(byte_in)) act = A_DONE;
            end
            P_LO: begin
                if (byte_in == OPC_ESC) begin
                    act      = A_ESC;
                    nxt_path = P_LO_E;
                end
            end
            P_HI: begin
                if (byte_in == OPC_ESC) begin
                    act      = A_ESC;
                    nxt_path = P_HI_E;
                end else if (byte_in == OPC_SPIN) begin
                    act = A_DONE;
                end
            end
            P_LO_E: begin
                if (tbl_lo_esc(byte_in)) act = A_DONE;
            end
            P_HI_E: begin
                if (tbl_hi_esc(byte_in)) act = A_DONE;
            end
            default: act = A_BAD;
        endcase
    end

endmodule

// File: rtl/opc_pc.sv
module opc_pc #(
    parameter int          AW       = 32,
    parameter logic [31:0] RESET_PC = 32'd1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    output logic [AW-1:0] pc
);

    localparam logic [AW-1:0] PC_RST = AW'(RESET_PC);

    logic [AW-1:0] pc_d, pc_q;

    always_comb begin
        pc_d = pc_q;
        if (load)      pc_d = load_val;
        else if (adv)  pc_d = pc_q + AW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= PC_RST;
        else        pc_q <= pc_d;
    end

    assign pc = pc_q;

endmodule

// File: rtl/opc_fetch_decoder.sv
module opc_fetch_decoder
    import opc_pkg::*;
#(
    parameter int          AW       = 32,
    parameter logic [31:0] RESET_PC = 32'd1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        step,
    input  logic [AW-1:0]               end_addr,
    output logic                        mem_rd,
    output logic [AW-1:0]               mem_addr,
    input  logic [BYTE_W-1:0]           mem_rdata,
    input  logic                        mem_fault,
    output logic [AW-1:0]               pc,
    output logic                        op_valid,
    output logic [MAX_BYTES*BYTE_W-1:0] op_bytes,
    output logic [LVL_W-1:0]            op_len,
    output logic [2:0]                  op_class,
    output logic                        op_halt,
    output logic [AW-1:0]               op_start,
    output logic                        err,
    output logic                        err_fault,
    output logic [LVL_W-1:0]            err_level,
    output logic [2:0]                  err_path
);

    localparam int             BUS_W    = MAX_BYTES * BYTE_W;
    localparam logic [LVL_W-1:0] LVL_TOP = LVL_W'(MAX_BYTES);

    typedef struct packed {
        st_e                st;
        logic [AW-1:0]      start;
        path_e              path;
        logic [LVL_W-1:0]   lvl;
        logic [BUS_W-1:0]   bytes;
        logic               vld;
        logic               halt;
        logic               err;
        logic               flt;
        logic [LVL_W-1:0]   elvl;
        path_e              epath;
    } regs_t;

    regs_t q, d;

    logic          pc_adv, pc_load;
    act_e          act;
    path_e         nxt_path;
    logic [LVL_W-1:0] lane;

    opc_classify u_cls (
        .path     (q.path),
        .byte_in  (mem_rdata),
        .act      (act),
        .nxt_path (nxt_path)
    );

    opc_pc #(.AW(AW), .RESET_PC(RESET_PC)) u_pc (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (pc_adv),
        .load     (pc_load),
        .load_val (end_addr),
        .pc       (pc)
    );

    assign lane = q.lvl - LVL_W'(1);

    always_comb begin
        d       = q;
        d.vld   = 1'b0;
        d.halt  = 1'b0;
        pc_adv  = 1'b0;
        pc_load = 1'b0;
        unique case (q.st)
            S_IDLE: begin
                if (step) begin
                    d.st    = S_FETCH;
                    d.start = pc;
                    d.path  = P_ONE;
                    d.lvl   = LVL_W'(1);
                    d.bytes = '0;
                end
            end
            S_FETCH: begin
                if (mem_fault) begin
                    d.st    = S_STOP;
                    d.err   = 1'b1;
                    d.flt   = 1'b1;
                    d.elvl  = q.lvl;
                    d.epath = q.path;
                end else begin
                    pc_adv = 1'b1;
                    for (int i = 0; i < MAX_BYTES; i++) begin
                        if (lane == LVL_W'(i)) d.bytes[i*BYTE_W +: BYTE_W] = mem_rdata;
                    end
                    unique case (act)
                        A_HALT: begin
                            pc_adv  = 1'b0;
                            pc_load = 1'b1;
                            d.vld   = 1'b1;
                            d.halt  = 1'b1;
                            d.st    = S_IDLE;
                        end
                        A_DONE: begin
                            d.vld = 1'b1;
                            d.st  = S_IDLE;
                        end
                        A_ESC: begin
                            if (q.lvl == LVL_TOP) begin
                                d.st    = S_STOP;
                                d.err   = 1'b1;
                                d.elvl  = q.lvl;
                                d.epath = q.path;
                            end else begin
                                d.path = nxt_path;
                                d.lvl  = q.lvl + LVL_W'(1);
                            end
                        end
                        default: begin
                            d.st    = S_STOP;
                            d.err   = 1'b1;
                            d.elvl  = q.lvl;
                            d.epath = q.path;
                        end
                    endcase
                end
            end
            S_STOP: begin
                d.st = S_STOP;
            end
            default: d.st = S_STOP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mem_rd    = (q.st == S_FETCH);
    assign mem_addr  = pc;
    assign op_valid  = q.vld;
    assign op_bytes  = q.bytes;
    assign op_len    = q.lvl;
    assign op_class  = q.path;
    assign op_halt   = q.halt;
    assign op_start  = q.start;
    assign err       = q.err;
    assign err_fault = q.flt;
    assign err_level = q.elvl;
    assign err_path  = q.epath;

endmodule

// File: rtl/opc_fetch_decoder_chk.sv
module opc_fetch_decoder_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] end_addr,
    input logic          mem_rd,
    input logic [AW-1:0] mem_addr,
    input logic          mem_fault,
    input logic [AW-1:0] pc,
    input logic          op_valid,
    input logic [1:0]    op_len,
    input logic [2:0]    op_class,
    input logic          op_halt,
    input logic [AW-1:0] op_start,
    input logic          err,
    input logic          err_fault,
    input logic [1:0]    err_level
);

    function automatic logic [1:0] len_of(input logic [2:0] c);
        if (c == 3'd0)                   return 2'd1;
        else if (c == 3'd3 || c == 3'd5) return 2'd3;
        else                             return 2'd2;
    endfunction

    p_fetch_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> mem_addr == pc);

    p_pc_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !mem_fault) |=> (op_halt ? (pc == $past(end_addr))
                                            : (pc == $past(mem_addr) + AW'(1))));

    p_halt_shape_r2: assert property (@(posedge clk) disable iff (!rst_n)
        op_halt |-> (op_valid && op_class == 3'd0 && op_len == 2'd1));

    p_len_class_r3: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |-> op_len == len_of(op_class));

    p_level_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> err_level != 2'd0);

    p_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !op_halt) |-> pc == op_start + AW'(op_len));

    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> (err && !mem_rd && !op_valid && $stable(pc)));

    p_fault_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && mem_fault) |=> (err && err_fault && pc == $past(pc)));

endmodule

bind opc_fetch_decoder opc_fetch_decoder_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .end_addr  (end_addr),
    .mem_rd    (mem_rd),
    .mem_addr  (mem_addr),
    .mem_fault (mem_fault),
    .pc        (pc),
    .op_valid  (op_valid),
    .op_len    (op_len),
    .op_class  (op_class),
    .op_halt   (op_halt),
    .op_start  (op_start),
    .err       (err),
    .err_fault (err_fault),
    .err_level (err_level)
);

// File: tb/opc_fetch_decoder_tb.sv
module opc_fetch_decoder_tb_top;

    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          step = 1'b0;
    logic [AW-1:0] end_addr = 32'h80;
    logic          mem_rd;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_rdata;
    logic          mem_fault;
    logic [AW-1:0] pc;
    logic          op_valid;
    logic [23:0]   op_bytes;
    logic [1:0]    op_len;
    logic [2:0]    op_class;
    logic          op_halt;
    logic [AW-1:0] op_start;
    logic          err;
    logic          err_fault;
    logic [1:0]    err_level;
    logic [2:0]    err_path;

    logic [7:0]    mem [256];
    logic          flt_en = 1'b0;
    logic [7:0]    flt_at = 8'h00;

    int n_chk = 0;
    int n_bad = 0;
    logic [AW-1:0] exp_pc;

    always #10 clk = ~clk;

    assign mem_rdata = mem[mem_addr[7:0]];
    assign mem_fault = flt_en && (mem_addr[7:0] == flt_at);

    opc_fetch_decoder #(.AW(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .step(step), .end_addr(end_addr),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .mem_fault(mem_fault), .pc(pc), .op_valid(op_valid),
        .op_bytes(op_bytes), .op_len(op_len), .op_class(op_class),
        .op_halt(op_halt), .op_start(op_start), .err(err),
        .err_fault(err_fault), .err_level(err_level), .err_path(err_path)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n  = 1'b0;
        flt_en = 1'b0;
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (2) @(negedge clk);
        rst_n  = 1'b1;
        exp_pc = 32'd1;
    endtask

    task automatic put3(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2);
        mem[exp_pc[7:0]]         = b0;
        mem[exp_pc[7:0] + 8'd1]  = b1;
        mem[exp_pc[7:0] + 8'd2]  = b2;
    endtask

    // pulse step and wait (at negedges) for a result strobe or an error
    task automatic issue(input string req, output bit got);
        got = 1'b0;
        @(negedge clk);
        step = 1'b1;
        @(negedge clk);
        step = 1'b0;
        for (int i = 0; i < 8; i++) begin
            if (op_valid || err) begin
                got = 1'b1;
                break;
            end
            @(negedge clk);
        end
        if (!got) begin
            n_chk++;
            n_bad++;
            $display("FAIL %s no result: actual none expected strobe", req);
        end
    endtask

    task automatic expect_op(input string req, input logic [7:0] b0, input logic [7:0] b1,
                             input logic [7:0] b2, input int len, input int cls);
        bit got;
        logic [23:0] eb;
        logic [AW-1:0] st;
        st = exp_pc;
        put3(b0, b1, b2);
        eb = {(len > 2) ? b2 : 8'h00, (len > 1) ? b1 : 8'h00, b0};
        issue(req, got);
        chk(req, "op_valid", op_valid, 1'b1);
        chk(req, "op_class", op_class, cls);
        chk(req, "op_len", op_len, len);
        chk({req, " R12"}, "op_bytes", op_bytes, eb);
        chk({req, " R8"}, "op_start", op_start, st);
        chk({req, " R1"}, "pc", pc, st + len);
        chk(req, "op_halt", op_halt, 1'b0);
        exp_pc = st + len;
    endtask

    task automatic expect_err(input string req, input logic [7:0] b0, input logic [7:0] b1,
                              input logic [7:0] b2, input int lvl, input int path,
                              input bit flt, input logic [AW-1:0] epc);
        bit got;
        do_reset();
        put3(b0, b1, b2);
        issue(req, got);
        chk(req, "err", err, 1'b1);
        chk(req, "err_fault", err_fault, flt);
        chk(req, "err_level", err_level, lvl);
        chk(req, "err_path", err_path, path);
        chk(req, "pc", pc, epc);
    endtask

    task automatic t_reset();
        do_reset();
        @(negedge clk);
        chk("R11", "pc", pc, 32'd1);
        chk("R11", "op_valid", op_valid, 1'b0);
        chk("R11", "err", err, 1'b0);
        chk("R11", "mem_rd", mem_rd, 1'b0);
    endtask

    task automatic t_singles();
        expect_op("R3 nop",     8'h90, 8'hEE, 8'hEE, 1, 0);
        expect_op("R3 push",    8'h55, 8'hEE, 8'hEE, 1, 0);
        expect_op("R3 ret",     8'hC3, 8'hEE, 8'hEE, 1, 0);
        expect_op("R3 pop",     8'h5F, 8'hEE, 8'hEE, 1, 0);
    endtask

    task automatic t_escape();
        expect_op("R4 jcc",     8'h0F, 8'h84, 8'hEE, 2, 1);
        expect_op("R4 imul",    8'h0F, 8'hAF, 8'hEE, 2, 1);
        expect_op("R5 hi spin", 8'hF3, 8'h90, 8'hEE, 2, 4);
    endtask

    task automatic t_three();
        expect_op("R6 lo esc",  8'hF2, 8'h0F, 8'h58, 3, 3);
        expect_op("R6 hi esc",  8'hF3, 8'h0F, 8'h2C, 3, 5);
        expect_op("R6 lo 11",   8'hF2, 8'h0F, 8'h11, 3, 3);
    endtask

    task automatic t_halt();
        bit got;
        put3(8'hF4, 8'h90, 8'h90);
        end_addr = 32'h80;
        issue("R2", got);
        chk("R2", "op_valid", op_valid, 1'b1);
        chk("R2", "op_halt", op_halt, 1'b1);
        chk("R2", "op_class", op_class, 0);
        chk("R2", "op_len", op_len, 1);
        chk("R2", "pc", pc, 32'h80);
        exp_pc = 32'h80;
        expect_op("R8 after halt", 8'hC3, 8'hEE, 8'hEE, 1, 0);
    endtask

    task automatic t_errors();
        logic [AW-1:0] hold;
        expect_err("R7 lvl1",       8'h00, 8'h00, 8'h00, 1, 0, 1'b0, 32'd2);
        // sticky stop: further steps do nothing
        hold = pc;
        @(negedge clk); step = 1'b1;
        @(negedge clk); step = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R9", "mem_rd", mem_rd, 1'b0);
            chk("R9", "op_valid", op_valid, 1'b0);
        end
        chk("R9", "err", err, 1'b1);
        chk("R9", "pc", pc, hold);
        expect_err("R7 esc lvl2",   8'h0F, 8'h05, 8'h00, 2, 1, 1'b0, 32'd3);
        expect_err("R5 lo needs esc", 8'hF2, 8'h90, 8'h00, 2, 2, 1'b0, 32'd3);
        expect_err("R7 hi esc lvl3", 8'hF3, 8'h0F, 8'h58, 3, 5, 1'b0, 32'd4);
        expect_err("R7 lo esc lvl3", 8'hF2, 8'h0F, 8'h2C, 3, 3, 1'b0, 32'd4);
    endtask

    task automatic t_fault();
        bit got;
        do_reset();
        put3(8'h0F, 8'h84, 8'h00);
        flt_at = 8'd2;
        flt_en = 1'b1;
        issue("R10", got);
        chk("R10", "err", err, 1'b1);
        chk("R10", "err_fault", err_fault, 1'b1);
        chk("R10", "err_level", err_level, 2);
        chk("R10", "err_path", err_path, 1);
        chk("R10", "pc", pc, 32'd2);
        chk("R10", "op_valid", op_valid, 1'b0);
        do_reset();
        put3(8'hF3, 8'h0F, 8'h10);
        flt_at = 8'd3;
        flt_en = 1'b1;
        issue("R10 lvl3", got);
        chk("R10 lvl3", "err_level", err_level, 3);
        chk("R10 lvl3", "err_path", err_path, 5);
        chk("R10 lvl3", "pc", pc, 32'd3);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_singles();
        t_escape();
        t_three();
        t_halt();
        t_errors();
        t_fault();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule